// File: doc/BRIEF.md
# Crowbar-Free Memory Cell Access Sequencer

This controller turns single read and write requests into the cycle-by-cycle word-line and bit-line control that a small static memory cell built from contact switches needs. In such a cell a feedback element and a pass gate both reach the storage node. If both drive it with opposite values at the same moment, a direct supply-to-ground path appears. Every write is therefore broken into a fixed series of phases. The feedback path is opened before the bit-line value reaches the node, and it is closed again only once the feedback output already equals the written value.

Two cell styles are supported. The three-element cell uses a separate pass device to break the loop. The two-element cell floats its feedback element by driving both of its actuation inputs to the same level. A mode input picks the style at the moment a request is accepted. The requester is stalled through a busy flag until the last phase has ended. A read takes one cycle, and its data is returned on the following edge. The bit-line is modelled as three separate signals: a drive value, a drive enable and a sensed value. The outer level resolves them into a true shared line.

Top module: `cell_access_seq`

## Requirements
- R1: While the synchronous active-high `rst` is high, and on the first cycle after it, the block is idle: `wlPass`=0, `wlLoop`=1 (loop closed), `blOe`=0, `busy`=0, `rdValid`=0. This holds even if an operation was in progress.
- R2: A read, accepted when `reqValid`=1 and `reqWrite`=0 while idle, spends exactly one cycle with `wlPass`=1, `wlLoop`=1 and `blOe`=0. On the edge that ends that cycle, `rdData` captures `blIn`, and `rdValid` is high for exactly one cycle.
- R3: With `modeSel`=0 (three-element cell), a write runs five phases, written as {`wlPass`,`wlLoop`,`blOe`}: open loop 000, drive node 101, propagate 101, close loop 111, release 010. It then returns to idle.
- R4: With `modeSel`=1 (two-element cell, where `wlLoop`=0 means the feedback element is floated), a write runs four phases: float 000, drive node 101, latch 111, release 010. It then returns to idle.
- R5: The bit-line drive never begins unless the loop was already open in the previous cycle. No cycle occurs in which the pass gate drives a value while the closed loop holds a different value.
- R6: `blOe` is high only while `wlPass` is high. While `blOe` is high, `blDrive` carries the write data captured at acceptance and does not change. At all other times `blOe`=0 and `blDrive`=0.
- R7: `busy` rises only on an accepted request and stays high through the last phase. `reqReady` is its inverse. A request presented while busy is ignored: it starts no operation and produces no read data.
- R8: `modeSel` is sampled only on the accepting edge. A change during an operation leaves that operation's phase sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 1 | Cell style: 0 three-element, 1 two-element |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 write, 0 read |
| reqData | input | DATA_W | Write data |
| reqReady | output | 1 | Request can be accepted this cycle |
| busy | output | 1 | Sequence in progress |
| wlPass | output | 1 | Pass-gate word-line |
| wlLoop | output | 1 | Feedback word-line, 1 = loop closed or element actuated |
| blOe | output | 1 | Bit-line drive enable |
| blDrive | output | DATA_W | Bit-line drive value |
| blIn | input | DATA_W | Sensed bit-line value |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | DATA_W | Read data |

## Verification
The assertions assume that `blIn` is only meaningful in a read cycle. They also assume that the surrounding logic never drives the bit-line itself while `blOe` is high. The bench's cell model drives `blIn` only when the pass gate is on and the controller has released the line. Requests are changed only on falling edges, and `rst` is asserted for whole cycles. This includes once in the middle of a write, so every property starts from a clean idle state. Both cell styles are swept across every data value. The bench also flips the mode and raises a refused request during some writes.

// File: rtl/cell_seq_pkg.sv
package cell_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_READ,
    S3_OPEN,
    S3_DRIVE,
    S3_PROP,
    S3_CLOSE,
    S3_REL,
    S2_FLOAT,
    S2_DRIVE,
    S2_LATCH,
    S2_REL
  } seqState_t;

  typedef struct packed {
    logic passOn;
    logic loopClosed;
    logic driveBl;
    logic sampleRd;
    logic capture;
  } cellStrobe_t;

  localparam logic MODE_THREE = 1'b0;
  localparam logic MODE_TWO   = 1'b1;

endpackage

// File: rtl/cell_seq_ctrl.sv
module cell_seq_ctrl
  import cell_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        modeSel,
  output cellStrobe_t strobe,
  output logic        busy
);

  seqState_t state, stateNext;
  logic      accept;

  assign accept = (state == S_IDLE) && reqValid;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        if (!reqWrite)               stateNext = S_READ;
        else if (modeSel == MODE_TWO) stateNext = S2_FLOAT;
        else                          stateNext = S3_OPEN;
      end
      S_READ:   stateNext = S_IDLE;
      S3_OPEN:  stateNext = S3_DRIVE;
      S3_DRIVE: stateNext = S3_PROP;
      S3_PROP:  stateNext = S3_CLOSE;
      S3_CLOSE: stateNext = S3_REL;
      S3_REL:   stateNext = S_IDLE;
      S2_FLOAT: stateNext = S2_DRIVE;
      S2_DRIVE: stateNext = S2_LATCH;
      S2_LATCH: stateNext = S2_REL;
      S2_REL:   stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    strobe            = '0;
    strobe.loopClosed = 1'b1;
    strobe.capture    = accept && reqWrite;
    unique case (state)
      S_READ:   begin strobe.passOn = 1'b1; strobe.sampleRd = 1'b1; end
      S3_OPEN,
      S2_FLOAT: strobe.loopClosed = 1'b0;
      S3_DRIVE,
      S3_PROP,
      S2_DRIVE: begin strobe.passOn = 1'b1; strobe.loopClosed = 1'b0; strobe.driveBl = 1'b1; end
      S3_CLOSE,
      S2_LATCH: begin strobe.passOn = 1'b1; strobe.driveBl = 1'b1; end
      default:  ;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reqValid));

  // R5
  loop_open_first_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.driveBl && !$past(strobe.driveBl)) |-> !$past(strobe.loopClosed));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && strobe.loopClosed && !strobe.passOn));

endmodule

// File: rtl/cell_seq_dp.sv
module cell_seq_dp
  import cell_seq_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cellStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] blIn,
  output logic              wlPass,
  output logic              wlLoop,
  output logic              blOe,
  output logic [DATA_W-1:0] blDrive,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] wrReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrReg   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.capture)  wrReg  <= reqData;
      if (strobe.sampleRd) rdData <= blIn;
      rdValid <= strobe.sampleRd;
    end
  end

  assign wlPass = strobe.passOn;
  assign wlLoop = strobe.loopClosed;
  assign blOe   = strobe.driveBl;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitDrive
    assign blDrive[i] = strobe.driveBl & wrReg[i];
  end

  // R6
  oe_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    blOe |-> wlPass);

  // R6
  drive_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (blOe && $past(blOe)) |-> $stable(blDrive));

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  // R5
  release_closed_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(blOe) |-> (!wlPass && wlLoop));

endmodule

// File: rtl/cell_access_seq.sv
module cell_access_seq
  import cell_seq_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeSel,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              busy,
  output logic              wlPass,
  output logic              wlLoop,
  output logic              blOe,
  output logic [DATA_W-1:0] blDrive,
  input  logic [DATA_W-1:0] blIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  cellStrobe_t strobe;

  cell_seq_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .modeSel  (modeSel),
    .strobe   (strobe),
    .busy     (busy)
  );

  cell_seq_dp #(.DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .reqData (reqData),
    .blIn    (blIn),
    .wlPass  (wlPass),
    .wlLoop  (wlLoop),
    .blOe    (blOe),
    .blDrive (blDrive),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

  assign reqReady = ~busy;

endmodule

// File: tb/test_cell_access_seq.sv
`timescale 1ns/1ps
module test_cell_access_seq;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         modeSel = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [W-1:0] reqData = '0;
  logic         reqReady, busy, wlPass, wlLoop, blOe, rdValid;
  logic [W-1:0] blDrive, blIn, rdData;

  int tests = 0;
  int fails = 0;
  int crowbarHits = 0;
  int modeCur = 0;
  logic [W-1:0] sn = '0;
  logic [W-1:0] fbOut = '0;

  always #2 clk = ~clk;

  cell_access_seq #(.DATA_W(W)) i_cell_access_seq (
    .clk(clk), .rst(rst), .modeSel(modeSel), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqData(reqData), .reqReady(reqReady),
    .busy(busy), .wlPass(wlPass), .wlLoop(wlLoop), .blOe(blOe),
    .blDrive(blDrive), .blIn(blIn), .rdValid(rdValid), .rdData(rdData)
  );

  // cell model: node value reaches the line only through an open pass gate
  assign blIn = (wlPass && !blOe) ? sn : '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (wlPass && blOe && wlLoop && (blDrive != fbOut)) crowbarHits++;
      if (modeCur == 0) begin
        if (!wlLoop) fbOut <= sn;
        if (wlPass && blOe) sn <= blDrive;
      end else begin
        if (wlPass && blOe) begin
          sn <= blDrive;
          if (!wlLoop) fbOut <= blDrive;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expPhase(input int m, input int p);
    if (m == 0) begin
      case (p)
        0: return 3'b000; 1: return 3'b101; 2: return 3'b101;
        3: return 3'b111; default: return 3'b010;
      endcase
    end else begin
      case (p)
        0: return 3'b000; 1: return 3'b101; 2: return 3'b111;
        default: return 3'b010;
      endcase
    end
  endfunction

  task automatic runWrite(input int m, input logic [W-1:0] d, input bit flipMode, input bit pokeBusy);
    int n;
    n = (m == 0) ? 5 : 4;
    @(negedge clk);
    modeCur = m; modeSel = m[0]; reqValid = 1'b1; reqWrite = 1'b1; reqData = d;
    chk(reqReady == 1'b1, "R7 ready when idle", reqReady, 1);
    @(negedge clk);
    if (pokeBusy) begin reqWrite = 1'b0; reqData = ~d; end
    else reqValid = 1'b0;
    if (flipMode) modeSel = ~modeSel;
    for (int p = 0; p < n; p++) begin
      if (p > 0) @(negedge clk);
      chk({wlPass, wlLoop, blOe} == expPhase(m, p),
          (m == 0) ? (flipMode ? "R3 R8 phase" : "R3 phase") : (flipMode ? "R4 R8 phase" : "R4 phase"),
          {wlPass, wlLoop, blOe}, expPhase(m, p));
      chk(busy && !reqReady, "R7 busy during write", {busy, reqReady}, 2);
      if (blOe) chk(blDrive == d, "R6 drive value", blDrive, d);
      else      chk(blDrive == '0, "R6 line released", blDrive, 0);
    end
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; modeSel = m[0];
    chk({wlPass, wlLoop, blOe, busy} == 4'b0100, "R7 idle after write",
        {wlPass, wlLoop, blOe, busy}, 4'b0100);
    chk(rdValid == 1'b0, "R7 refused read gave no data", rdValid, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R7 refused request not started", busy, 0);
  endtask

  task automatic runRead(input int m, input logic [W-1:0] expd);
    @(negedge clk);
    modeSel = m[0]; reqValid = 1'b1; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk({wlPass, wlLoop, blOe} == 3'b110, "R2 read phase", {wlPass, wlLoop, blOe}, 3'b110);
    chk(busy && !rdValid, "R2 read busy", {busy, rdValid}, 2);
    @(negedge clk);
    chk(rdValid && rdData == expd, "R2 read data", {rdValid, rdData}, {1'b1, expd});
    chk(!busy, "R2 read done in one cycle", busy, 0);
    @(negedge clk);
    chk(!rdValid, "R2 valid one cycle", rdValid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({wlPass, wlLoop, blOe, busy, rdValid} == 5'b01000, "R1 reset outputs",
        {wlPass, wlLoop, blOe, busy, rdValid}, 5'b01000);
    rst = 1'b0;
    @(negedge clk);
    chk({wlPass, wlLoop, blOe, busy} == 4'b0100, "R1 idle after reset",
        {wlPass, wlLoop, blOe, busy}, 4'b0100);

    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < (1 << W); d++) begin
        runWrite(m, d[W-1:0], d == 5, d == 9);
        runRead(m, d[W-1:0]);
      end
    end

    // R1 reset in the middle of a write
    @(negedge clk);
    modeCur = 0; modeSel = 1'b0; reqValid = 1'b1; reqWrite = 1'b1; reqData = 4'hA;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({wlPass, wlLoop, blOe, busy} == 4'b0100, "R1 reset aborts write",
        {wlPass, wlLoop, blOe, busy}, 4'b0100);
    rst = 1'b0;
    runWrite(1, 4'h6, 1'b0, 1'b0);
    runRead(1, 4'h6);

    chk(crowbarHits == 0, "R5 opposing drivers", crowbarHits, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule